// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the eight-bit status byte of an I2C bus controller. Three of its bits are sticky flags that it owns. The first shows that this controller is driving a transfer as bus master. The second records that it lost arbitration to another master. The third notes that the first byte after a start carried an extension-code address. The five low bits pass straight through from the bus engine. The engine feeds the block single-cycle event pulses: start issued, start seen, stop seen, arbitration lost, and SCL rising edge. It also supplies the address byte as it is shifted in. Alongside the pulses come a release command, an enable level, and a read strobe from the processor side.

Each flag has its own set and clear events. When a set and a clear hit the same flag in one cycle, the set wins. Dropping the enable overrides everything. A processor read clears the arbitration flag, but only when the read is permitted and only one cycle after the strobe, so the read itself still sees the flag. The extension-code flag is sampled on the eighth SCL rising edge of the first byte after a detected start. All interfaces are plain level or pulse pins with no handshake and no back-pressure. The status byte is always valid and may be sampled in any cycle.

Top module: `i2c_stat_reg`

## Requirements
- R1: While reset is held and in the first cycle after it, with all inputs low, `status` reads 0x00. Bit 7 is the master flag, bit 6 the arbitration-lost flag and bit 5 the extension-code flag.
- R2: A `start_gen` pulse with `en` high sets bit 7 at the next clock edge, and the bit holds afterwards.
- R3: A `stop_det` pulse or a `comm_release` pulse clears bit 7 at the next clock edge.
- R4: An `arb_loss` pulse sets bit 6 and clears bit 7 at the next edge, even when `start_gen` is high in the same cycle.
- R5: When `rd_strobe` is high and `rd_permit` is high, bit 6 keeps its value after the next edge and is cleared at the edge after that.
- R6: A `rd_strobe` with `rd_permit` low leaves bit 6 unchanged.
- R7: For a flag that receives a set event and a clear event in the same cycle, the set wins.
- R8: Bit 5 is set at the eighth SCL rising edge after a `start_det` when `addr_byte[7:4]` is 0000 or 1111 in that cycle. For any other prefix it stays 0.
- R9: Bit 5 is cleared by `start_det`, `stop_det` or `comm_release`.
- R10: Only the first byte after a start is examined. A new `start_det` or a `stop_det` restarts the count of SCL edges from zero.
- R11: While `en` is low, bits 7 to 5 are 0 at every edge and all events are ignored. This takes priority over any set.
- R12: Bits 4 to 0 follow `coin_in`, `xmit_in`, `ack_in`, `std_in` and `spd_in` respectively, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Controller enable level |
| start_gen | input | 1 | Pulse: this controller issued a start |
| start_det | input | 1 | Pulse: start condition seen on the bus |
| stop_det | input | 1 | Pulse: stop condition seen on the bus |
| arb_loss | input | 1 | Pulse: arbitration lost |
| scl_rise | input | 1 | Pulse: SCL rising edge |
| addr_byte | input | 8 | Address byte as currently shifted in |
| comm_release | input | 1 | Pulse: release the bus and drop out of the transfer |
| rd_strobe | input | 1 | Processor read of the status byte |
| rd_permit | input | 1 | High when a read is allowed (start trigger set or wait period) |
| coin_in | input | 1 | Address-match bit, passed to bit 4 |
| xmit_in | input | 1 | Transmit-direction bit, passed to bit 3 |
| ack_in | input | 1 | Acknowledge-detected bit, passed to bit 2 |
| std_in | input | 1 | Start-detected bit, passed to bit 1 |
| spd_in | input | 1 | Stop-detected bit, passed to bit 0 |
| status | output | 8 | Status byte |

## Verification
The extension-code detector is driven with three address prefixes: 0x0_, 0xF_ and 0x5_. These separate the all-zero match, the all-one match and a miss. The bench also runs a first byte followed by a matching second byte, which shows that only the first byte is examined. A start repeated in the middle of a byte shows that the edge count restarts. Further runs apply a set and a clear to the same flag in one cycle, in several pairings, to show which event wins. Reads with and without permission, and events while disabled, confirm that the arbitration flag and the other flags are left alone when they should be.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W     = 8;
  localparam int BIT_MASTER = 7;
  localparam int BIT_ARB    = 6;
  localparam int BIT_EXT    = 5;
  localparam int PASS_W     = 5;

  // A prefix is an extension code when all its bits are equal.
  function automatic logic prefix_is_ext(input logic [3:0] hi);
    return (hi == 4'h0) || (hi == 4'hF);
  endfunction
endpackage

// File: rtl/stat_edge_ctr.sv
module stat_edge_ctr #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_det,
  stop_det,
  input  logic scl_rise,
  output logic sample_o
);
  localparam int CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_BITS - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          last_edge;

  assign last_edge = armed_q && scl_rise && (cnt_q == LAST);
  assign sample_o  = en && last_edge && !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || stop_det) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_det) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (armed_q && scl_rise) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stat_master_flags.sv
module stat_master_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_gen,
  input  logic stop_det,
  input  logic arb_loss,
  input  logic comm_release,
  input  logic rd_take,
  output logic master_q,
  output logic arb_q
);
  logic rd_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      master_q  <= 1'b0;
      arb_q     <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_take;
      // Losing arbitration forces the master bit low, even over a start.
      if (arb_loss)                    master_q <= 1'b0;
      else if (start_gen)              master_q <= 1'b1;
      else if (stop_det || comm_release) master_q <= 1'b0;
      // The read clear lands one cycle late, so a new loss still wins.
      if (arb_loss)       arb_q <= 1'b1;
      else if (rd_pend_q) arb_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_ext_flag.sv
module stat_ext_flag #(
  parameter int PREFIX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                sample,
  input  logic [PREFIX_W-1:0] prefix,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic                comm_release,
  output logic                ext_q
);
  logic match;
  assign match = (prefix == '0) || (prefix == '1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en)                              ext_q <= 1'b0;
    else if (sample && match)                       ext_q <= 1'b1;
    else if (start_det || stop_det || comm_release) ext_q <= 1'b0;
  end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PREFIX_W  = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_gen,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              arb_loss,
  input  logic              scl_rise,
  input  logic [ADDR_W-1:0] addr_byte,
  input  logic              comm_release,
  input  logic              rd_strobe,
  input  logic              rd_permit,
  input  logic              coin_in,
  input  logic              xmit_in,
  input  logic              ack_in,
  input  logic              std_in,
  input  logic              spd_in,
  output logic [STAT_W-1:0] status
);
  localparam int LO_W = ADDR_W - PREFIX_W;

  logic sample, master_q, arb_q, ext_q;
  logic [PASS_W-1:0] pass_bits;
  logic unused_addr_lo;

  assign unused_addr_lo = ^addr_byte[LO_W-1:0];

  stat_edge_ctr #(.BYTE_BITS(BYTE_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .start_det(start_det),
    .stop_det(stop_det), .scl_rise(scl_rise), .sample_o(sample)
  );

  stat_master_flags u_mst (
    .clk(clk), .rst_n(rst_n), .en(en), .start_gen(start_gen),
    .stop_det(stop_det), .arb_loss(arb_loss), .comm_release(comm_release),
    .rd_take(rd_strobe && rd_permit), .master_q(master_q), .arb_q(arb_q)
  );

  stat_ext_flag #(.PREFIX_W(PREFIX_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .en(en), .sample(sample),
    .prefix(addr_byte[ADDR_W-1 -: PREFIX_W]), .start_det(start_det),
    .stop_det(stop_det), .comm_release(comm_release), .ext_q(ext_q)
  );

  assign pass_bits = {coin_in, xmit_in, ack_in, std_in, spd_in};

  always_comb begin
    status             = '0;
    status[BIT_MASTER] = master_q;
    status[BIT_ARB]    = arb_q;
    status[BIT_EXT]    = ext_q;
    for (int i = 0; i < PASS_W; i++) status[i] = pass_bits[i];
  end
endmodule

// File: rtl/i2c_stat_reg_chk.sv
module i2c_stat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       start_gen,
  input logic       stop_det,
  input logic       arb_loss,
  input logic       comm_release,
  input logic       rd_strobe,
  input logic       rd_permit,
  input logic [7:0] status
);
  AST_MASTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_gen && !arb_loss) |=> status[7]); // R2

  AST_MASTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_det || comm_release) && !start_gen && !arb_loss) |=> !status[7]); // R3

  AST_ARB_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && arb_loss) |=> (status[6] && !status[7])); // R4

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && status[6] && rd_strobe && rd_permit) |=> status[6]); // R5

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !arb_loss && $past(en && rd_strobe && rd_permit)) |=> !status[6]); // R5

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (status[7:5] == 3'b000)); // R11
endmodule

bind i2c_stat_reg i2c_stat_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start_gen(start_gen),
  .stop_det(stop_det), .arb_loss(arb_loss), .comm_release(comm_release),
  .rd_strobe(rd_strobe), .rd_permit(rd_permit), .status(status)
);

// File: tb/i2c_stat_reg_bench.sv
module i2c_stat_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] EN = 9'h001, PM = 9'h002, SC = 9'h004, SG = 9'h008,
                         SD = 9'h010, SP = 9'h020, AL = 9'h040, RL = 9'h080,
                         RD = 9'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, start_gen = 0, start_det = 0, stop_det = 0, arb_loss = 0;
  logic scl_rise = 0, comm_release = 0, rd_strobe = 0, rd_permit = 0;
  logic [7:0] addr_byte = '0;
  logic [4:0] lowv = '0, stage_low = '0;
  logic [7:0] status;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] m_exp;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_reg u_i2c_stat_reg (
    .clk(clk), .rst_n(rst_n), .en(en), .start_gen(start_gen),
    .start_det(start_det), .stop_det(stop_det), .arb_loss(arb_loss),
    .scl_rise(scl_rise), .addr_byte(addr_byte), .comm_release(comm_release),
    .rd_strobe(rd_strobe), .rd_permit(rd_permit), .coin_in(lowv[4]),
    .xmit_in(lowv[3]), .ack_in(lowv[2]), .std_in(lowv[1]), .spd_in(lowv[0]),
    .status(status)
  );

  // Driver: one cycle of stimulus, expected byte after the next edge queued.
  task automatic ev(input logic [8:0] m, input logic [7:0] addr,
                    input logic [7:0] exp, input string tag);
    @(negedge clk);
    en = m[0]; rd_permit = m[1]; scl_rise = m[2]; start_gen = m[3];
    start_det = m[4]; stop_det = m[5]; arb_loss = m[6];
    comm_release = m[7]; rd_strobe = m[8]; addr_byte = addr; lowv = stage_low;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: pop and compare a quarter period after each edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      checks++;
      if (status !== m_exp) begin
        errors++;
        $display("FAIL %s: status actual %h expected %h", m_tag, status, m_exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (status !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset: actual %h expected 00", status);
    end
    rst_n = 1'b1;
    ev(EN, 0, 8'h00, "R1 idle after reset");
    // Master flag
    ev(EN|SG, 0, 8'h80, "R2 start issued");
    ev(EN, 0, 8'h80, "R2 hold");
    ev(EN|SP, 0, 8'h00, "R3 stop clears");
    ev(EN|SG, 0, 8'h80, "R2 start again");
    ev(EN|RL, 0, 8'h00, "R3 release clears");
    ev(EN|SG, 0, 8'h80, "R2 start before loss");
    ev(EN|AL, 0, 8'h40, "R4 loss sets arb clears master");
    ev(EN, 0, 8'h40, "R4 hold");
    // Read clear
    ev(EN|PM|RD, 0, 8'h40, "R5 value kept after read");
    ev(EN, 0, 8'h00, "R5 cleared one cycle later");
    ev(EN|AL, 0, 8'h40, "R4 loss again");
    ev(EN|RD, 0, 8'h40, "R6 unpermitted read");
    ev(EN, 0, 8'h40, "R6 still set");
    ev(EN, 0, 8'h40, "R6 still set later");
    ev(EN|PM|RD, 0, 8'h40, "R5 permitted read");
    ev(EN, 0, 8'h00, "R5 cleared");
    // Priority
    ev(EN|AL, 0, 8'h40, "R7 arm");
    ev(EN|PM|RD, 0, 8'h40, "R7 read");
    ev(EN|AL, 0, 8'h40, "R7 loss beats pending read clear");
    ev(EN, 0, 8'h40, "R7 hold");
    ev(EN|PM|RD, 0, 8'h40, "R5 read");
    ev(EN, 0, 8'h00, "R5 cleared");
    ev(EN|SG|SP, 0, 8'h80, "R7 start beats stop");
    ev(EN|SG|AL, 0, 8'h40, "R4 loss beats start");
    ev(EN|PM|RD, 0, 8'h40, "R5 read");
    ev(EN, 0, 8'h00, "R5 cleared");
    ev(EN|SP, 0, 8'h00, "R3 idle");
    // Extension code, 0x0_
    ev(EN|SD, 0, 8'h00, "R8 start seen");
    for (int i = 0; i < 7; i++) ev(EN|SC, 8'h05, 8'h00, "R8 before eighth edge");
    ev(EN|SC, 8'h05, 8'h20, "R8 prefix 0000");
    ev(EN|SC, 8'h05, 8'h20, "R8 ninth edge keeps");
    ev(EN|SP, 0, 8'h00, "R9 stop clears ext");
    // 0xF_
    ev(EN|SD, 0, 8'h00, "R8 start seen");
    for (int i = 0; i < 8; i++) ev(EN|SC, 8'hF3, (i == 7) ? 8'h20 : 8'h00, "R8 prefix 1111");
    ev(EN|SD, 0, 8'h00, "R9 start clears ext");
    // Miss, then second byte ignored
    for (int i = 0; i < 8; i++) ev(EN|SC, 8'h52, 8'h00, "R8 prefix 0101 misses");
    for (int i = 0; i < 8; i++) ev(EN|SC, 8'h0A, 8'h00, "R10 second byte ignored");
    // Release clears ext
    ev(EN|SD, 0, 8'h00, "R8 start seen");
    for (int i = 0; i < 8; i++) ev(EN|SC, 8'h0F, (i == 7) ? 8'h20 : 8'h00, "R8 match");
    ev(EN|RL, 0, 8'h00, "R9 release clears ext");
    // Restart mid-byte
    ev(EN|SD, 0, 8'h00, "R10 start");
    for (int i = 0; i < 4; i++) ev(EN|SC, 8'hF0, 8'h00, "R10 partial byte");
    ev(EN|SD, 0, 8'h00, "R10 repeated start");
    for (int i = 0; i < 7; i++) ev(EN|SC, 8'hF0, 8'h00, "R10 count restarted");
    ev(EN|SC, 8'hF0, 8'h20, "R10 eighth edge after restart");
    ev(EN|SP, 0, 8'h00, "R9 stop");
    // Disable
    ev(EN|SG, 0, 8'h80, "R2 master");
    ev(EN|SD, 0, 8'h80, "R8 start seen");
    for (int i = 0; i < 8; i++) ev(EN|SC, 8'h00, (i == 7) ? 8'hA0 : 8'h80, "R8 with master");
    ev(SG, 0, 8'h00, "R11 disable beats set");
    ev(AL, 0, 8'h00, "R11 loss ignored");
    ev(EN, 0, 8'h00, "R11 re-enabled clean");
    // Pass-through
    stage_low = 5'h15;
    ev(EN, 0, 8'h15, "R12 low bits 10101");
    stage_low = 5'h0A;
    ev(EN|SG, 0, 8'h8A, "R12 low bits 01010");
    stage_low = 5'h00;
    ev(EN|SP, 0, 8'h00, "R12 low bits clear");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule